// File: doc/BRIEF.md
# Quad-Channel PWM Timer with Break Protection

This block is an up-counting timer that generates four pulse-width-modulated outputs, each with an optional complementary output. All four channels run from one time base: a shared prescaler divides the clock by PSC+1, and a shared counter runs from 0 to PERIOD and wraps. Every channel compares the counter against its own compare value. A channel output is active while the counter is below that value. Software controls the block through a small word-addressed register bus. Reads are registered, and writes use per-byte strobes.

The prescaler, the period and the compare values are held in shadow registers. An update event copies them into the active registers. An update event happens on every counter wrap, and software can force one by writing the trigger bit. The period shadow can be bypassed by clearing the period-preload bit, and the compare shadow can be bypassed per channel. A main output gate controls every output. Two break inputs, each with its own enable, active level and glitch filter, can shut the gate down. An automatic re-arm option reopens the gate at the first update event after the break has cleared.

Register map (word addresses): 0 control, 1 prescaler, 2 period, 3 channel enables, 4 mode for channels 0/1, 5 mode for channels 2/3, 6 break control, 7 counter (read only), 8..11 compare for channels 0..3.

Top module: `quad_pwm_timer`

## Requirements
- R1: A write to word address A updates only the bytes whose strobe bit is set. A read returns the addressed register on `bus_rdata` in the clock after `bus_rd`. Bits that are not implemented read 0 after a write of all ones: the period, prescaler and compare registers keep only their low 16 bits, the mode registers keep only mask 0x7878, and the channel-enable register keeps only mask 0xFFFF (0x3333 when complementary outputs are not built).
- R2: The counter advances once every PSC+1 clocks and wraps from PERIOD to 0. It is shared by all channels.
- R3: The counter advances only while control bit 0 (run) is 1. When run is 0 the counter value read at address 7 does not change.
- R4: Writing 1 to control bit 2 starts an update event. The event clears the counter and the prescaler and copies the shadowed prescaler, period and compare values into use. Control bit 2 always reads 0. A counter wrap is also an update event.
- R5: With control bit 1 (period preload) set, a period write takes effect only at the next update event. With bit 1 clear, it takes effect at once.
- R6: When a channel's mode field [6:4] is 3'b110, its output is active for exactly CMP clocks out of every PERIOD+1 counts. A CMP above PERIOD gives 100% duty, and CMP = 0 gives 0% duty.
- R7: When bit 3 of a channel's mode field is set, a compare write is held until the next update event. When bit 3 is clear, the write takes effect at once. The mode fields sit at bits [7:0] and [15:8] of addresses 4 (channels 0, 1) and 5 (channels 2, 3).
- R8: Channel c has a nibble at bits [4c+3:4c] of address 3: bit 0 output enable, bit 1 output polarity, bit 2 complementary enable, bit 3 complementary polarity. A polarity bit of 1 inverts the output. A disabled output rests at its polarity bit.
- R9: An enabled complementary output is active exactly when the main raw output is inactive.
- R10: While the main output gate (address 6 bit 0) is 0, every output sits at its own polarity level.
- R11: Break input b (address 6: enables at bits 2 and 8, active levels at bits 3 and 9, filters at [7:4] and [15:12]) is accepted only after it has been at its active level for N consecutive clocks, where N is its filter value. A filter value of 0 or 1 accepts the first sample.
- R12: An accepted break clears the main output gate. Software cannot set the gate again while a break is still accepted.
- R13: When auto re-arm (address 6 bit 1) is set, the gate sets itself at the first update event after the break is no longer accepted. When bit 1 is clear, the gate stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write enables |
| bus_rdata | output | 32 | Registered read data |
| brk_in | input | 2 | Break inputs |
| pwm_out | output | 4 | Main channel outputs |
| pwm_out_n | output | 4 | Complementary channel outputs |

## Verification
The hardest behaviour to reach from the ports is the boundary of the break filter, together with the auto re-arm path. The first needs a pulse that is exactly one clock shorter than the filter length. The second needs a break that stays asserted across several counter wraps, followed by a release and then a wrap. The bench drives break pulses of controlled length on clock boundaries. It holds a break for more than two periods and checks that the gate stays shut. It then releases the break and checks that the gate reopens only after a wrap. The shadowing of the period register cannot be seen directly, so the bench runs the counter for an exact number of clocks, stops it, and reads the counter. The value read tells whether the old period or the new one was in use.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_BRK = 2;
  localparam int FLT_W   = 4;

  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_PSC     = 4'd1;
  localparam logic [3:0] A_PERIOD  = 4'd2;
  localparam logic [3:0] A_CHEN    = 4'd3;
  localparam logic [3:0] A_MODE_LO = 4'd4;
  localparam logic [3:0] A_MODE_HI = 4'd5;
  localparam logic [3:0] A_BRK     = 4'd6;
  localparam logic [3:0] A_COUNT   = 4'd7;

  localparam logic [2:0] MODE_PWM1 = 3'b110;

  localparam logic [31:0] MODE_MASK = 32'h0000_7878;
  localparam logic [31:0] BRK_MASK  = 32'h0000_F3FF;

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  strb);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      res[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/ptm_timebase.sv
module ptm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ug,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf
);
  logic [PSC_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_en;
  logic             at_top;

  assign tick_en = run && (pre_q >= psc);
  assign at_top  = (cnt_q >= arr);
  assign ovf     = tick_en && at_top && !ug;
  assign cnt_val = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || ug) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (tick_en) begin
        pre_q <= '0;
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptm_brk_filter.sv
module ptm_brk_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brk_in,
  input  logic          en,
  input  logic          lvl,
  input  logic [FW-1:0] flt,
  output logic          fire
);
  logic [FW-1:0] run_q;
  logic          hit;

  assign hit  = en && (brk_in == lvl);
  assign fire = hit && (({1'b0, run_q} + 1'b1) >= {1'b0, flt});

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      run_q <= '0;
    end else if (run_q != {FW{1'b1}}) begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptm_channel.sv
module ptm_channel
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp,
  input  logic [3:0]       en,
  input  logic [3:0]       mode,
  input  logic             moe,
  output logic             out_p,
  output logic             out_n
);
  logic raw;

  assign raw = (mode[3:1] == MODE_PWM1) && (cnt_val < cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_p <= 1'b0;
      out_n <= 1'b0;
    end else begin
      out_p <= (moe && en[0]) ? (raw ^ en[1])  : en[1];
      out_n <= (moe && en[2]) ? (!raw ^ en[3]) : en[3];
    end
  end
endmodule

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 16,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [3:0]                       addr,
  input  logic [31:0]                      wdata,
  input  logic [3:0]                       wstrb,
  output logic [31:0]                      rdata,
  input  logic [CNT_W-1:0]                 cnt_val,
  input  logic                             ovf,
  input  logic                             brk_any,
  output logic                             run,
  output logic                             ug,
  output logic                             upd,
  output logic [PSC_W-1:0]                 psc_act,
  output logic [CNT_W-1:0]                 arr_act,
  output logic [NUM_CH-1:0][CNT_W-1:0]     cmp_act,
  output logic [NUM_CH-1:0][3:0]           ch_en,
  output logic [NUM_CH-1:0][3:0]           ch_mode,
  output logic                             moe,
  output logic [NUM_BRK-1:0]               brk_en,
  output logic [NUM_BRK-1:0]               brk_lvl,
  output logic [NUM_BRK-1:0][FLT_W-1:0]    brk_flt
);
  localparam logic [31:0] CHEN_MASK = HAS_COMP ? 32'h0000_FFFF : 32'h0000_3333;

  logic                         ctrl_run;
  logic                         ctrl_arpe;
  logic [PSC_W-1:0]             psc_sh;
  logic [CNT_W-1:0]             arr_sh;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_sh;
  logic [15:0]                  chen_r;
  logic [15:0]                  mode_lo;
  logic [15:0]                  mode_hi;
  logic [15:1]                  brk_hi;
  logic [31:0]                  cur_val;
  logic [31:0]                  merged;
  logic                         is_cmp;

  assign is_cmp = (addr[3:2] == 2'b10);

  always_comb begin
    cur_val = '0;
    case (addr)
      A_CTRL:    cur_val = {30'd0, ctrl_arpe, ctrl_run};
      A_PSC:     cur_val = 32'(psc_sh);
      A_PERIOD:  cur_val = 32'(arr_sh);
      A_CHEN:    cur_val = {16'd0, chen_r};
      A_MODE_LO: cur_val = {16'd0, mode_lo};
      A_MODE_HI: cur_val = {16'd0, mode_hi};
      A_BRK:     cur_val = {16'd0, brk_hi, moe};
      A_COUNT:   cur_val = 32'(cnt_val);
      default: begin
        if (is_cmp) cur_val = 32'(cmp_sh[addr[1:0]]);
      end
    endcase
  end

  assign merged = merge_bytes(cur_val, wdata, wstrb);
  assign ug     = wr_en && (addr == A_CTRL) && wstrb[0] && wdata[2];
  assign upd    = ug || ovf;
  assign run    = ctrl_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_run  <= 1'b0;
      ctrl_arpe <= 1'b0;
      psc_sh    <= '0;
      arr_sh    <= '0;
      cmp_sh    <= '0;
      chen_r    <= '0;
      mode_lo   <= '0;
      mode_hi   <= '0;
      brk_hi    <= '0;
      psc_act   <= '0;
      arr_act   <= '0;
      cmp_act   <= '0;
      moe       <= 1'b0;
      rdata     <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTRL:    {ctrl_arpe, ctrl_run} <= merged[1:0];
          A_PSC:     psc_sh  <= merged[PSC_W-1:0];
          A_PERIOD:  arr_sh  <= merged[CNT_W-1:0];
          A_CHEN:    chen_r  <= merged[15:0] & CHEN_MASK[15:0];
          A_MODE_LO: mode_lo <= merged[15:0] & MODE_MASK[15:0];
          A_MODE_HI: mode_hi <= merged[15:0] & MODE_MASK[15:0];
          A_BRK:     brk_hi  <= merged[15:1] & BRK_MASK[15:1];
          default: begin
            if (is_cmp) cmp_sh[addr[1:0]] <= merged[CNT_W-1:0];
          end
        endcase
      end

      if (upd) psc_act <= psc_sh;
      if (upd || !ctrl_arpe) arr_act <= arr_sh;
      for (int c = 0; c < NUM_CH; c++) begin
        if (upd || !ch_mode[c][0]) cmp_act[c] <= cmp_sh[c];
      end

      if (brk_any) begin
        moe <= 1'b0;
      end else if (wr_en && (addr == A_BRK) && wstrb[0]) begin
        moe <= wdata[0];
      end else if (brk_hi[1] && upd) begin
        moe <= 1'b1;
      end

      if (rd_en) rdata <= cur_val;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
    assign ch_en[c] = chen_r[4*c +: 4];
    if (c < 2) begin : g_lo
      assign ch_mode[c] = mode_lo[8*c+3 +: 4];
    end else begin : g_hi
      assign ch_mode[c] = mode_hi[8*(c-2)+3 +: 4];
    end
  end

  assign brk_en  = {brk_hi[8], brk_hi[2]};
  assign brk_lvl = {brk_hi[9], brk_hi[3]};
  assign brk_flt = {brk_hi[15:12], brk_hi[7:4]};
endmodule

// File: rtl/quad_pwm_timer.sv
module quad_pwm_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 16,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_wstrb,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  brk_in,
  output logic [3:0]  pwm_out,
  output logic [3:0]  pwm_out_n
);
  logic                          run;
  logic                          ug;
  logic                          upd;
  logic                          ovf;
  logic                          moe;
  logic                          brk_any;
  logic [CNT_W-1:0]              cnt_val;
  logic [PSC_W-1:0]              psc_act;
  logic [CNT_W-1:0]              arr_act;
  logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act;
  logic [NUM_CH-1:0][3:0]        ch_en;
  logic [NUM_CH-1:0][3:0]        ch_mode;
  logic [NUM_BRK-1:0]            brk_en;
  logic [NUM_BRK-1:0]            brk_lvl;
  logic [NUM_BRK-1:0][FLT_W-1:0] brk_flt;
  logic [NUM_BRK-1:0]            brk_fire;
  logic [NUM_CH-1:0]             pol_vec;

  ptm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .HAS_COMP(HAS_COMP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .wstrb(bus_wstrb), .rdata(bus_rdata),
    .cnt_val(cnt_val), .ovf(ovf), .brk_any(brk_any),
    .run(run), .ug(ug), .upd(upd), .psc_act(psc_act), .arr_act(arr_act),
    .cmp_act(cmp_act), .ch_en(ch_en), .ch_mode(ch_mode), .moe(moe),
    .brk_en(brk_en), .brk_lvl(brk_lvl), .brk_flt(brk_flt)
  );

  ptm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst(rst), .run(run), .ug(ug), .psc(psc_act), .arr(arr_act),
    .cnt_val(cnt_val), .ovf(ovf)
  );

  for (genvar b = 0; b < NUM_BRK; b++) begin : g_brk
    ptm_brk_filter #(.FW(FLT_W)) u_flt (
      .clk(clk), .rst(rst), .brk_in(brk_in[b]), .en(brk_en[b]),
      .lvl(brk_lvl[b]), .flt(brk_flt[b]), .fire(brk_fire[b])
    );
  end

  assign brk_any = |brk_fire;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ptm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt_val(cnt_val), .cmp(cmp_act[c]),
      .en(ch_en[c]), .mode(ch_mode[c]), .moe(moe),
      .out_p(pwm_out[c]), .out_n(pwm_out_n[c])
    );
    assign pol_vec[c] = ch_en[c][1];
  end
endmodule

// File: rtl/quad_pwm_timer_chk.sv
module quad_pwm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ug,
  input logic             moe,
  input logic             brk_any,
  input logic [CNT_W-1:0] cnt_val,
  input logic [3:0]       pol_vec,
  input logic [3:0]       pwm_out,
  input logic [1:0]       brk_in,
  input logic [1:0]       brk_en,
  input logic [1:0]       brk_lvl,
  input logic [1:0]       brk_fire
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ug) |=> ((cnt_val == $past(cnt_val)) || (cnt_val == $past(cnt_val) + 1'b1) || (cnt_val == '0)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !ug) |=> $stable(cnt_val));

  // R4
  upd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ug |=> (cnt_val == '0));

  // R10
  gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !moe |=> (pwm_out == $past(pol_vec)));

  // R11
  brk0_level_chk: assert property (@(posedge clk) disable iff (rst)
    brk_fire[0] |-> (brk_en[0] && (brk_in[0] == brk_lvl[0])));

  // R11
  brk1_level_chk: assert property (@(posedge clk) disable iff (rst)
    brk_fire[1] |-> (brk_en[1] && (brk_in[1] == brk_lvl[1])));

  // R12
  brk_gate_chk: assert property (@(posedge clk) disable iff (rst)
    brk_any |=> !moe);
endmodule

bind quad_pwm_timer quad_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ug(ug), .moe(moe), .brk_any(brk_any),
  .cnt_val(cnt_val), .pol_vec(pol_vec), .pwm_out(pwm_out), .brk_in(brk_in),
  .brk_en(brk_en), .brk_lvl(brk_lvl), .brk_fire(brk_fire)
);

// File: tb/test_quad_pwm_timer.sv
`timescale 1ns/1ps
module test_quad_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  brk_in = 2'b10;
  logic [3:0]  pwm_out;
  logic [3:0]  pwm_out_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int hp [4];
  int hn [4];

  always #10 clk = ~clk;

  quad_pwm_timer i_quad_pwm_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .brk_in(brk_in), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < 4; c++) begin hp[c] = 0; hn[c] = 0; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        hp[c] += int'(pwm_out[c]);
        hn[c] += int'(pwm_out_n[c]);
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'd0, d);  chk("R1", "control after reset", d, 32'h0);
    rd(4'd6, d);  chk("R10", "break reg after reset", d, 32'h0);
    chk("R10", "outputs after reset", {24'd0, pwm_out_n, pwm_out}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, d); chk("R1", "period width", d, 32'h0000_FFFF);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, d); chk("R1", "mode mask", d, 32'h0000_7878);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d); chk("R1", "enable mask", d, 32'h0000_FFFF);
    wr(4'd10, 32'h0000_1234);
    wr(4'd10, 32'h0000_FFFF, 4'b0010); rd(4'd10, d); chk("R1", "byte strobe", d, 32'h0000_FF34);
    wr(4'd3, 32'h0); wr(4'd4, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(4'd1, 32'd2); wr(4'd2, 32'd9); wr(4'd0, 32'h4);
    rd(4'd7, d); chk("R4", "count after trigger", d, 32'd0);
    rd(4'd0, d); chk("R4", "trigger bit reads 0", d, 32'd0);
    wr(4'd0, 32'h1); tick(7); wr(4'd0, 32'h0);
    rd(4'd7, d); chk("R2", "prescaled count after 9 clocks", d, 32'd3);
    tick(5);
    rd(4'd7, d); chk("R3", "count frozen while stopped", d, 32'd3);
    wr(4'd0, 32'h4);
    rd(4'd7, d); chk("R4", "trigger clears counter", d, 32'd0);
  endtask

  task automatic t_period_preload;
    logic [31:0] d;
    wr(4'd1, 32'd0); wr(4'd2, 32'd3); wr(4'd0, 32'h4);
    wr(4'd0, 32'h2); wr(4'd2, 32'd9);
    wr(4'd0, 32'h3); tick(6); wr(4'd0, 32'h2);
    rd(4'd7, d); chk("R5", "shadowed period applied at wrap", d, 32'd4);
    wr(4'd0, 32'h0); wr(4'd2, 32'd3); wr(4'd0, 32'h4);
    wr(4'd0, 32'h1); tick(6); wr(4'd0, 32'h0);
    rd(4'd7, d); chk("R5", "direct period write", d, 32'd0);
  endtask

  task automatic t_duty;
    wr(4'd1, 32'd0); wr(4'd2, 32'd9);
    wr(4'd3, 32'h0000_1115);
    wr(4'd4, 32'h0000_6060); wr(4'd5, 32'h0000_6060);
    wr(4'd8, 32'd3); wr(4'd9, 32'd0); wr(4'd10, 32'd12); wr(4'd11, 32'd9);
    wr(4'd6, 32'h1);
    wr(4'd0, 32'h4); wr(4'd0, 32'h1);
    tick(5); measure(10);
    chk("R6", "ch0 duty 3/10", hp[0], 3);
    chk("R9", "ch0 complement 7/10", hn[0], 7);
    chk("R6", "ch1 zero compare", hp[1], 0);
    chk("R6", "ch2 compare above period", hp[2], 10);
    chk("R2", "ch3 duty 9/10 shared period", hp[3], 9);
    chk("R8", "ch1 complement disabled", hn[1], 0);
    wr(4'd1, 32'd1); wr(4'd0, 32'h5);
    tick(5); measure(20);
    chk("R2", "ch0 duty with prescale 2", hp[0], 6);
  endtask

  task automatic t_polarity;
    wr(4'd1, 32'd0); wr(4'd0, 32'h5);
    wr(4'd3, 32'h0000_112F);
    tick(5); measure(10);
    chk("R8", "inverted ch0", hp[0], 7);
    chk("R9", "inverted complement", hn[0], 3);
    chk("R8", "disabled ch1 rests at polarity", hp[1], 10);
  endtask

  task automatic t_cmp_preload;
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h0000_0011); wr(4'd4, 32'h0000_6068);
    wr(4'd8, 32'd0); wr(4'd9, 32'd0); wr(4'd0, 32'h4);
    tick(3);
    chk("R6", "zero compare stopped", {28'd0, pwm_out}, 32'h0);
    wr(4'd8, 32'd5); wr(4'd9, 32'd5); tick(3);
    chk("R7", "preloaded ch0 held", {31'd0, pwm_out[0]}, 32'd0);
    chk("R7", "direct ch1 applied", {31'd0, pwm_out[1]}, 32'd1);
    wr(4'd0, 32'h4); tick(3);
    chk("R7", "preloaded ch0 after trigger", {31'd0, pwm_out[0]}, 32'd1);
  endtask

  task automatic t_gate;
    wr(4'd3, 32'h0000_0031); wr(4'd6, 32'h0); tick(3);
    chk("R10", "ch0 gated", {31'd0, pwm_out[0]}, 32'd0);
    chk("R10", "ch1 gated to polarity", {31'd0, pwm_out[1]}, 32'd1);
    wr(4'd6, 32'h1); tick(3);
    chk("R10", "ch0 ungated", {31'd0, pwm_out[0]}, 32'd1);
    chk("R8", "ch1 active-low driven", {31'd0, pwm_out[1]}, 32'd0);
  endtask

  task automatic t_break;
    logic [31:0] d;
    wr(4'd3, 32'h0000_0011); wr(4'd6, 32'h3D);
    @(negedge clk); brk_in[0] = 1'b1; tick(2); brk_in[0] = 1'b0; tick(3);
    rd(4'd6, d); chk("R11", "short pulse rejected", d, 32'h3D);
    chk("R11", "output kept", {31'd0, pwm_out[0]}, 32'd1);
    @(negedge clk); brk_in[0] = 1'b1; tick(5);
    chk("R12", "output forced inactive", {31'd0, pwm_out[0]}, 32'd0);
    rd(4'd6, d); chk("R11", "long pulse accepted", d, 32'h3C);
    wr(4'd6, 32'h3D); rd(4'd6, d); chk("R12", "gate set refused in break", d, 32'h3C);
    brk_in[0] = 1'b0; tick(3);
    rd(4'd6, d); chk("R13", "no re-arm without auto", d, 32'h3C);
    wr(4'd6, 32'h101); tick(2);
    rd(4'd6, d); chk("R11", "second input armed", d, 32'h101);
    @(negedge clk); brk_in[1] = 1'b0; @(negedge clk); brk_in[1] = 1'b1; tick(2);
    rd(4'd6, d); chk("R11", "zero filter accepts one sample", d, 32'h100);
  endtask

  task automatic t_auto_rearm;
    logic [31:0] d;
    wr(4'd1, 32'd0); wr(4'd2, 32'd9);
    wr(4'd3, 32'h0000_0001); wr(4'd4, 32'h0000_0060); wr(4'd8, 32'd3);
    wr(4'd0, 32'h4); wr(4'd0, 32'h1);
    wr(4'd6, 32'h103);
    @(negedge clk); brk_in[1] = 1'b0; tick(25);
    rd(4'd6, d); chk("R13", "gate shut across wraps", d, 32'h102);
    measure(10); chk("R12", "no pulses in break", hp[0], 0);
    brk_in[1] = 1'b1; tick(15);
    rd(4'd6, d); chk("R13", "gate re-armed at update", d, 32'h103);
    measure(10); chk("R13", "pulses resume", hp[0], 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_prescale();
    t_period_preload();
    t_duty();
    t_polarity();
    t_cmp_preload();
    t_gate();
    t_break();
    t_auto_rearm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule